// File: doc/BRIEF.md
# Function unit operand collector

This block sits in front of an execution pipeline and gathers every source operand of one operation before the pipeline sees it. When an operation is issued, the block takes the decoded operation word, the current instruction address and a mask that says which register operands must be read. For each register operand it holds a read request to the register file side. The data is captured only in the one cycle in which the matching grant pulse arrives, because the value is never offered again. Grants may come in any order, one at a time or several together.

Once every requested operand has been captured, the block offers the complete bundle to the pipeline with a valid/ready handshake. It then waits for the pipeline's results. Each result carries its own enable flag, and the block raises a write request only for the enabled results. It drops each write request when that result's write grant arrives. When no write request remains, it returns to idle. If the pipeline reports no result to write, for example a branch that is not taken and updates neither link nor counter, the block returns to idle at once.

Top module: `opnd_collector`

## Requirements
- R1: After reset the block is idle: `busy_o`, `pipe_valid_o`, every bit of `rd_req_o` and every bit of `wr_req_o` are 0.
- R2: An issue pulse accepted while idle sets `busy_o` at the next edge and raises `rd_req_o` exactly on the bits set in `issue_mask_i` (bit i = operand slot i). `issue_op_i` and `issue_cia_i` are captured at issue and later appear unchanged on `pipe_op_o` and `pipe_cia_o`.
- R3: The operand data on slot i of `rd_data_i` (bits i*64 upward) is captured at the edge where `rd_go_i[i]` is high while `rd_req_o[i]` is high. `rd_req_o[i]` is low after that edge, and later changes on `rd_data_i` do not alter the captured value.
- R4: Grants may arrive in any order, and several grants in one cycle are all captured at that edge.
- R5: A grant on a slot that has no pending request is ignored. A slot outside the issue mask is presented as zero in `pipe_opnd_o`, and an already captured slot keeps its first value.
- R6: `pipe_valid_o` rises at the edge that captures the last pending operand, or at the issue edge when the mask is empty. It stays high, with a stable bundle, until `pipe_ready_i` is seen high at an edge, and is low after that edge.
- R7: `wr_req_o` is all zero from issue until the pipeline's results are accepted, in particular whenever any read request is pending.
- R8: While waiting for results, a `res_valid_i` pulse raises `wr_req_o` exactly on the bits of `res_ok_i` and presents the matching `res_data_i` slot (bits j*64 upward) on `wr_data_o`.
- R9: `wr_req_o[j]` drops at the edge where `wr_go_i[j]` is seen. `busy_o` falls at the edge where the last write request is granted, including when all are granted in one cycle.
- R10: If `res_ok_i` is all zero when results are accepted, no write request is raised and `busy_o` falls at that same edge.
- R11: `issue_i` while `busy_o` is high has no effect on the requests, the operation word, the address or the captured operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_i | input | 1 | Issue pulse for a new operation |
| issue_mask_i | input | NUM_RD | Register operands to be read |
| issue_op_i | input | OP_W | Decoded operation word |
| issue_cia_i | input | CIA_W | Current instruction address |
| busy_o | output | 1 | Unit holds an operation |
| rd_req_o | output | NUM_RD | Per-operand read request |
| rd_go_i | input | NUM_RD | Per-operand one-shot read grant |
| rd_data_i | input | NUM_RD*DATA_W | Operand data, slot i at bits i*DATA_W |
| pipe_valid_o | output | 1 | Bundle offered to the pipeline |
| pipe_ready_i | input | 1 | Pipeline accepts the bundle |
| pipe_op_o | output | OP_W | Operation word of the bundle |
| pipe_cia_o | output | CIA_W | Instruction address of the bundle |
| pipe_opnd_o | output | NUM_RD*DATA_W | Captured operands |
| res_valid_i | input | 1 | Pipeline returns results |
| res_ok_i | input | NUM_WR | Per-result write enable |
| res_data_i | input | NUM_WR*DATA_W | Result data, slot j at bits j*DATA_W |
| wr_req_o | output | NUM_WR | Per-result write request |
| wr_go_i | input | NUM_WR | Per-result write grant |
| wr_data_o | output | NUM_WR*DATA_W | Result data to be written |

## Verification
The cases that matter are those where the last operand grant and another event land in the same cycle. In one scenario all three grants arrive in a single cycle while a second issue pulse is driven. The bench then expects the bundle to be offered with the original operation word, the full data set and no new requests. In another, both write grants come in one cycle, and the bench expects the requests cleared and `busy_o` low at that edge. A result set with no enabled result is also sent together with an issue pulse. The bench expects the unit to go idle with no read requests raised.

// File: rtl/oc_pkg.sv
package oc_pkg;
    typedef enum logic [2:0] {
        OC_IDLE,
        OC_GATHER,
        OC_OFFER,
        OC_EXEC,
        OC_DRAIN
    } oc_state_e;
endpackage

// File: rtl/oc_rd_slot.sv
module oc_rd_slot #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic              need_i,
    input  logic              go_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              pend_o,
    output logic [DATA_W-1:0] val_o
);
    typedef struct packed {
        logic              pend;
        logic [DATA_W-1:0] val;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (arm_i) begin
            slot_d.pend = need_i;
            slot_d.val  = '0;
        end else if (go_i && slot_q.pend) begin
            slot_d.pend = 1'b0;
            slot_d.val  = data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign pend_o = slot_q.pend;
    assign val_o  = slot_q.val;
endmodule

// File: rtl/oc_wr_slot.sv
module oc_wr_slot #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic              ok_i,
    input  logic [DATA_W-1:0] res_i,
    input  logic              go_i,
    output logic              req_o,
    output logic [DATA_W-1:0] data_o
);
    typedef struct packed {
        logic              req;
        logic [DATA_W-1:0] data;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (arm_i) begin
            slot_d.req  = ok_i;
            slot_d.data = res_i;
        end else if (go_i && slot_q.req) begin
            slot_d.req = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign req_o  = slot_q.req;
    assign data_o = slot_q.data;
endmodule

// File: rtl/opnd_collector.sv
module opnd_collector #(
    parameter int NUM_RD = 3,
    parameter int NUM_WR = 2,
    parameter int DATA_W = 64,
    parameter int OP_W   = 16,
    parameter int CIA_W  = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     issue_i,
    input  logic [NUM_RD-1:0]        issue_mask_i,
    input  logic [OP_W-1:0]          issue_op_i,
    input  logic [CIA_W-1:0]         issue_cia_i,
    output logic                     busy_o,
    output logic [NUM_RD-1:0]        rd_req_o,
    input  logic [NUM_RD-1:0]        rd_go_i,
    input  logic [NUM_RD*DATA_W-1:0] rd_data_i,
    output logic                     pipe_valid_o,
    input  logic                     pipe_ready_i,
    output logic [OP_W-1:0]          pipe_op_o,
    output logic [CIA_W-1:0]         pipe_cia_o,
    output logic [NUM_RD*DATA_W-1:0] pipe_opnd_o,
    input  logic                     res_valid_i,
    input  logic [NUM_WR-1:0]        res_ok_i,
    input  logic [NUM_WR*DATA_W-1:0] res_data_i,
    output logic [NUM_WR-1:0]        wr_req_o,
    input  logic [NUM_WR-1:0]        wr_go_i,
    output logic [NUM_WR*DATA_W-1:0] wr_data_o
);
    import oc_pkg::*;

    typedef struct packed {
        oc_state_e        st;
        logic [OP_W-1:0]  op;
        logic [CIA_W-1:0] cia;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              issue_take;
    logic              res_take;
    logic [NUM_RD-1:0] rd_left;
    logic [NUM_WR-1:0] wr_left;

    assign issue_take = issue_i && (ctl_q.st == OC_IDLE);
    assign res_take   = res_valid_i && (ctl_q.st == OC_EXEC);
    assign rd_left    = rd_req_o & ~rd_go_i;
    assign wr_left    = wr_req_o & ~wr_go_i;

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            OC_IDLE: begin
                if (issue_i) begin
                    ctl_d.op  = issue_op_i;
                    ctl_d.cia = issue_cia_i;
                    ctl_d.st  = (issue_mask_i == '0) ? OC_OFFER : OC_GATHER;
                end
            end
            OC_GATHER: begin
                if (rd_left == '0) ctl_d.st = OC_OFFER;
            end
            OC_OFFER: begin
                if (pipe_ready_i) ctl_d.st = OC_EXEC;
            end
            OC_EXEC: begin
                if (res_valid_i) ctl_d.st = (res_ok_i == '0) ? OC_IDLE : OC_DRAIN;
            end
            OC_DRAIN: begin
                if (wr_left == '0) ctl_d.st = OC_IDLE;
            end
            default: ctl_d.st = OC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st  <= OC_IDLE;
            ctl_q.op  <= '0;
            ctl_q.cia <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    for (genvar i = 0; i < NUM_RD; i++) begin : g_rd
        oc_rd_slot #(.DATA_W(DATA_W)) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .arm_i  (issue_take),
            .need_i (issue_mask_i[i]),
            .go_i   (rd_go_i[i]),
            .data_i (rd_data_i[i*DATA_W +: DATA_W]),
            .pend_o (rd_req_o[i]),
            .val_o  (pipe_opnd_o[i*DATA_W +: DATA_W])
        );
    end

    for (genvar j = 0; j < NUM_WR; j++) begin : g_wr
        oc_wr_slot #(.DATA_W(DATA_W)) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .arm_i  (res_take),
            .ok_i   (res_ok_i[j]),
            .res_i  (res_data_i[j*DATA_W +: DATA_W]),
            .go_i   (wr_go_i[j]),
            .req_o  (wr_req_o[j]),
            .data_o (wr_data_o[j*DATA_W +: DATA_W])
        );
    end

    assign busy_o       = (ctl_q.st != OC_IDLE);
    assign pipe_valid_o = (ctl_q.st == OC_OFFER);
    assign pipe_op_o    = ctl_q.op;
    assign pipe_cia_o   = ctl_q.cia;
endmodule

// File: rtl/oc_chk.sv
module oc_chk #(
    parameter int NUM_RD = 3,
    parameter int NUM_WR = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic [NUM_RD-1:0] rd_req_o,
    input logic [NUM_RD-1:0] rd_go_i,
    input logic              pipe_valid_o,
    input logic              pipe_ready_i,
    input logic [NUM_WR-1:0] wr_req_o,
    input logic [NUM_WR-1:0] wr_go_i
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (rd_req_o == '0) && (wr_req_o == '0) && !pipe_valid_o);

    // R3
    rd_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        |(rd_req_o & rd_go_i) |=> ((rd_req_o & $past(rd_req_o & rd_go_i)) == '0));

    // R6
    offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_valid_o && !pipe_ready_i) |=> pipe_valid_o);

    // R6
    offer_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_valid_o && pipe_ready_i) |=> !pipe_valid_o);

    // R7
    no_write_while_reading_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o != '0) |-> (wr_req_o == '0));

    // R9
    wr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        |(wr_req_o & wr_go_i) |=> ((wr_req_o & $past(wr_req_o & wr_go_i)) == '0));
endmodule

bind opnd_collector oc_chk #(.NUM_RD(NUM_RD), .NUM_WR(NUM_WR)) u_oc_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy_o       (busy_o),
    .rd_req_o     (rd_req_o),
    .rd_go_i      (rd_go_i),
    .pipe_valid_o (pipe_valid_o),
    .pipe_ready_i (pipe_ready_i),
    .wr_req_o     (wr_req_o),
    .wr_go_i      (wr_go_i)
);

// File: tb/opnd_collector_test.sv
module opnd_collector_test;
    localparam int CLK_PERIOD = 10;
    localparam int NR = 3;
    localparam int NW = 2;
    localparam int DW = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              issue_i = 1'b0;
    logic [NR-1:0]     issue_mask_i = '0;
    logic [15:0]       issue_op_i = '0;
    logic [63:0]       issue_cia_i = '0;
    logic              busy_o;
    logic [NR-1:0]     rd_req_o;
    logic [NR-1:0]     rd_go_i = '0;
    logic [NR*DW-1:0]  rd_data_i = '0;
    logic              pipe_valid_o;
    logic              pipe_ready_i = 1'b0;
    logic [15:0]       pipe_op_o;
    logic [63:0]       pipe_cia_o;
    logic [NR*DW-1:0]  pipe_opnd_o;
    logic              res_valid_i = 1'b0;
    logic [NW-1:0]     res_ok_i = '0;
    logic [NW*DW-1:0]  res_data_i = '0;
    logic [NW-1:0]     wr_req_o;
    logic [NW-1:0]     wr_go_i = '0;
    logic [NW*DW-1:0]  wr_data_o;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    opnd_collector uut (
        .clk(clk), .rst_n(rst_n),
        .issue_i(issue_i), .issue_mask_i(issue_mask_i),
        .issue_op_i(issue_op_i), .issue_cia_i(issue_cia_i),
        .busy_o(busy_o), .rd_req_o(rd_req_o), .rd_go_i(rd_go_i),
        .rd_data_i(rd_data_i), .pipe_valid_o(pipe_valid_o),
        .pipe_ready_i(pipe_ready_i), .pipe_op_o(pipe_op_o),
        .pipe_cia_o(pipe_cia_o), .pipe_opnd_o(pipe_opnd_o),
        .res_valid_i(res_valid_i), .res_ok_i(res_ok_i),
        .res_data_i(res_data_i), .wr_req_o(wr_req_o),
        .wr_go_i(wr_go_i), .wr_data_o(wr_data_o)
    );

    task automatic chk(input string req, input logic [191:0] act, input logic [191:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_issue(input logic [NR-1:0] m, input logic [15:0] op, input logic [63:0] cia);
        issue_i = 1'b1; issue_mask_i = m; issue_op_i = op; issue_cia_i = cia;
        step();
        issue_i = 1'b0;
    endtask

    task automatic do_grant(input logic [NR-1:0] g, input logic [NR*DW-1:0] d);
        rd_go_i = g; rd_data_i = d;
        step();
        rd_go_i = '0;
    endtask

    task automatic do_accept();
        pipe_ready_i = 1'b1;
        step();
        pipe_ready_i = 1'b0;
    endtask

    task automatic do_result(input logic [NW-1:0] ok, input logic [NW*DW-1:0] d);
        res_valid_i = 1'b1; res_ok_i = ok; res_data_i = d;
        step();
        res_valid_i = 1'b0;
    endtask

    task automatic do_wgrant(input logic [NW-1:0] g);
        wr_go_i = g;
        step();
        wr_go_i = '0;
    endtask

    task automatic t_reset();
        chk("R1 busy", busy_o, 0);
        chk("R1 rd_req", rd_req_o, 0);
        chk("R1 wr_req", wr_req_o, 0);
        chk("R1 valid", pipe_valid_o, 0);
    endtask

    task automatic t_one_by_one();
        logic [63:0] a = 64'hA0A0_0000_0000_0001;
        logic [63:0] b = 64'hB1B1_0000_0000_0002;
        logic [63:0] c = 64'hC2C2_0000_0000_0003;
        do_issue(3'b111, 16'h1234, 64'h0000_0000_0000_4000);
        chk("R2 busy", busy_o, 1);
        chk("R2 rd_req", rd_req_o, 3'b111);
        chk("R7 wr_req idle", wr_req_o, 0);
        do_grant(3'b100, {c, 64'hDEAD, 64'hDEAD});
        chk("R4 rd_req after slot2", rd_req_o, 3'b011);
        do_grant(3'b001, {64'hBEEF, 64'hBEEF, a});
        chk("R3 rd_req after slot0", rd_req_o, 3'b010);
        chk("R6 not yet valid", pipe_valid_o, 0);
        rd_data_i = {64'h1111, 64'h2222, 64'h3333};
        step();
        chk("R3 held without grant", rd_req_o, 3'b010);
        do_grant(3'b010, {64'h5555, b, 64'h6666});
        chk("R6 valid after last", pipe_valid_o, 1);
        chk("R3 bundle", pipe_opnd_o, {c, b, a});
        chk("R2 op", pipe_op_o, 16'h1234);
        chk("R2 cia", pipe_cia_o, 64'h4000);
        step();
        chk("R6 held until ready", pipe_valid_o, 1);
        chk("R6 bundle stable", pipe_opnd_o, {c, b, a});
        do_accept();
        chk("R6 dropped after ready", pipe_valid_o, 0);
        chk("R7 no write before result", wr_req_o, 0);
        do_result(2'b11, {64'h7777, 64'h8888});
        chk("R8 wr_req", wr_req_o, 2'b11);
        chk("R8 wr_data", wr_data_o, {64'h7777, 64'h8888});
        do_wgrant(2'b01);
        chk("R9 partial grant", wr_req_o, 2'b10);
        chk("R9 still busy", busy_o, 1);
        do_wgrant(2'b10);
        chk("R9 released", busy_o, 0);
        chk("R9 wr_req clear", wr_req_o, 0);
    endtask

    task automatic t_all_at_once();
        do_issue(3'b111, 16'h00AA, 64'h8000);
        issue_i = 1'b1; issue_mask_i = 3'b000; issue_op_i = 16'hFFFF; issue_cia_i = 64'h9;
        do_grant(3'b111, {64'h3, 64'h2, 64'h1});
        issue_i = 1'b0;
        chk("R4 same-cycle valid", pipe_valid_o, 1);
        chk("R4 same-cycle bundle", pipe_opnd_o, {64'h3, 64'h2, 64'h1});
        chk("R11 op kept", pipe_op_o, 16'h00AA);
        chk("R11 cia kept", pipe_cia_o, 64'h8000);
        chk("R11 no new req", rd_req_o, 0);
        do_accept();
        do_result(2'b11, {64'h44, 64'h55});
        do_wgrant(2'b11);
        chk("R9 both granted release", busy_o, 0);
        chk("R9 both cleared", wr_req_o, 0);
    endtask

    task automatic t_sparse();
        do_issue(3'b010, 16'h0101, 64'h100);
        chk("R2 sparse req", rd_req_o, 3'b010);
        do_grant(3'b101, {64'hAAAA, 64'hBBBB, 64'hCCCC});
        chk("R5 stray grant ignored", rd_req_o, 3'b010);
        chk("R5 not valid", pipe_valid_o, 0);
        do_grant(3'b010, {64'hAAAA, 64'h1234, 64'hCCCC});
        chk("R5 bundle zeros", pipe_opnd_o, {64'h0, 64'h1234, 64'h0});
        do_accept();
        issue_i = 1'b1; issue_mask_i = 3'b111;
        do_result(2'b00, {64'h1, 64'h2});
        issue_i = 1'b0;
        chk("R10 idle", busy_o, 0);
        chk("R10 no wr_req", wr_req_o, 0);
        chk("R11 issue at result ignored", rd_req_o, 0);
    endtask

    task automatic t_empty();
        do_issue(3'b000, 16'h0E0E, 64'h200);
        chk("R6 empty mask valid", pipe_valid_o, 1);
        chk("R5 empty bundle", pipe_opnd_o, 0);
        chk("R2 empty op", pipe_op_o, 16'h0E0E);
        do_accept();
        do_result(2'b01, {64'h99, 64'h42});
        chk("R8 single ok", wr_req_o, 2'b01);
        chk("R8 single data", wr_data_o[63:0], 64'h42);
        do_wgrant(2'b10);
        chk("R9 unrelated grant", wr_req_o, 2'b01);
        do_wgrant(2'b01);
        chk("R9 single release", busy_o, 0);
    endtask

    initial begin
        repeat (3) step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_one_by_one();
        t_all_at_once();
        t_sparse();
        t_empty();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule